// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This block converts an accepted interrupt or trap request into the 24-bit start address of its service routine. Every routine address sits in a 256-byte vector table. Each table entry is two bytes long, and an 8-bit offset inside a 64 KiB segment selects it. The unit builds the table pointer and reads the two bytes through a byte-wide read port. It then presents the segment joined with the 16-bit routine address, together with a one-cycle completion strobe.

Four request kinds exist. A power-on reset reads the fixed slot at physical address zero. A divide-by-zero trap reads a fixed slot in the current code segment. A top-level interrupt reads a fixed slot in the interrupt segment. A peripheral interrupt reads a slot chosen by a shared vector register. Software programs the upper bits of that register as a base. Hardware fills the low bits from the channel number, so up to four channels share one register. The divide-by-zero trap also raises a flag that tells the core not to save the flag register, so that this trap returns like a subroutine.

Top module: `ivec_fetch`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd_en` and `no_flag_save` are 0, and the vector register base is 0. A peripheral request on channel 2 with no prior write therefore reads offset 04h.
- R2: Kind 0 (reset) reads physical addresses 000000h and 000001h, and the upper byte of `target` is 00h.
- R3: Kind 1 (divide-by-zero) reads offsets 02h and 03h of the segment on `code_seg`, and `code_seg` forms the upper byte of `target`.
- R4: Kind 2 (top-level) reads offsets 04h and 05h of the segment on `int_seg`, and `int_seg` forms the upper byte of `target`.
- R5: Kind 3 (peripheral) reads from the segment on `int_seg`. The even offset is {base[4:0], req_chan[1:0], 0}, where the base is the stored upper five bits of the vector register.
- R6: A write to the vector register stores `vreg_wdata[7:3]` as the base. Bits 2:0 of the write data have no effect on any offset.
- R7: Bits 15:8 of a segment address are always 0. The even byte is read in the cycle after acceptance, and the odd byte is read in the cycle after that. The read data returns one cycle after each read strobe. The even byte becomes `target[15:8]` and the odd byte becomes `target[7:0]`.
- R8: `done` goes high for exactly one cycle, three cycles after the first read strobe. `target` is valid while `done` is high.
- R9: `no_flag_save` is high together with `done` for kind 1 only, and is low at all other times.
- R10: A request that arrives while `busy` is high is ignored. No additional reads occur and the result belongs to the first request.
- R11: The segment inputs are sampled when a request is accepted. Later changes to them do not alter the reads or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_kind | input | 2 | 0 reset, 1 divide-by-zero, 2 top-level, 3 peripheral |
| req_chan | input | 2 | Channel number for peripheral requests |
| vreg_wr | input | 1 | Write strobe for the vector register |
| vreg_wdata | input | 8 | Vector register write data, bits 7:3 kept |
| int_seg | input | 8 | Interrupt segment number |
| code_seg | input | 8 | Current code segment number |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| busy | output | 1 | A fetch is in progress |
| mem_rd_en | output | 1 | Read strobe |
| mem_addr | output | 24 | Read byte address |
| done | output | 1 | One-cycle completion pulse |
| target | output | 24 | {segment, routine address} |
| no_flag_save | output | 1 | Flag register must not be saved (divide-by-zero only) |

## Verification
The hardest situations to reach are a second request arriving in the middle of a fetch and a segment input changing after acceptance. In both, the visible effect is the absence of a change. The bench raises a competing request of another kind during the odd-byte read cycle, and it inverts both segment inputs in the cycle after acceptance. In each case it records every read strobe up to several cycles past the completion pulse. This confirms that exactly two reads took place and that the result still matches the first request's slot and segment.

// File: rtl/ivf_pkg.sv
package ivf_pkg;
   typedef enum logic [1:0] {
      K_RESET  = 2'd0,
      K_DIVZ   = 2'd1,
      K_TOP    = 2'd2,
      K_PERIPH = 2'd3
   } req_kind_t;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_RD0  = 2'd1,
      S_RD1  = 2'd2,
      S_CAP  = 2'd3
   } fetch_state_t;
endpackage

// File: rtl/ivf_vecreg.sv
module ivf_vecreg #(
   parameter int VEC_W  = 8,
   parameter int CHAN_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [VEC_W-1:0]  wr_data,
   input  logic [CHAN_W-1:0] chan,
   output logic [VEC_W-1:0]  periph_off
);
   localparam int BASE_W = VEC_W - CHAN_W - 1;

   logic [BASE_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     base_q <= '0;
      else if (wr_en) base_q <= wr_data[VEC_W-1:CHAN_W+1];
   end

   assign periph_off = {base_q, chan, 1'b0};

   a_r6_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(base_q));
   a_r6_base_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> base_q == $past(wr_data[VEC_W-1:CHAN_W+1]));
endmodule

// File: rtl/ivf_slot_sel.sv
module ivf_slot_sel
   import ivf_pkg::*;
#(
   parameter int SEG_W = 8,
   parameter int VEC_W = 8
) (
   input  req_kind_t         kind,
   input  logic [SEG_W-1:0]  int_seg,
   input  logic [SEG_W-1:0]  code_seg,
   input  logic [VEC_W-1:0]  periph_off,
   output logic [SEG_W-1:0]  seg,
   output logic [VEC_W-1:0]  off
);
   localparam logic [VEC_W-1:0] OFF_DIVZ = VEC_W'(2);
   localparam logic [VEC_W-1:0] OFF_TOP  = VEC_W'(4);

   always_comb begin
      unique case (kind)
         K_RESET:  begin seg = '0;       off = '0;         end
         K_DIVZ:   begin seg = code_seg; off = OFF_DIVZ;   end
         K_TOP:    begin seg = int_seg;  off = OFF_TOP;    end
         default:  begin seg = int_seg;  off = periph_off; end
      endcase
   end
endmodule

// File: rtl/ivf_seq.sv
module ivf_seq
   import ivf_pkg::*;
#(
   parameter int SEG_W    = 8,
   parameter int VEC_W    = 8,
   parameter int DATA_W   = 8,
   parameter bit HI_FIRST = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  req_kind_t                   kind,
   input  logic [SEG_W-1:0]            seg_in,
   input  logic [VEC_W-1:0]            off_in,
   input  logic [DATA_W-1:0]           rd_data,
   output logic                        busy,
   output logic                        rd_en,
   output logic [SEG_W+2*DATA_W-1:0]   rd_addr,
   output logic                        done,
   output logic [SEG_W+2*DATA_W-1:0]   target,
   output logic                        no_flag_save
);
   localparam int ROUT_W = 2 * DATA_W;
   localparam int ADDR_W = SEG_W + ROUT_W;
   localparam int PAD_W  = ROUT_W - VEC_W;

   fetch_state_t        state_q;
   req_kind_t           kind_q;
   logic [SEG_W-1:0]    seg_q;
   logic [VEC_W-1:0]    off_q;
   logic [DATA_W-1:0]   first_q;
   logic [ROUT_W-1:0]   routine;
   logic                accept;

   assign accept = req_valid && (state_q == S_IDLE);
   assign busy   = (state_q != S_IDLE);
   assign rd_en  = (state_q == S_RD0) || (state_q == S_RD1);

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_addr = {seg_q, {PAD_W{1'b0}}, off_q[VEC_W-1:1], state_q == S_RD1};
      end else begin : g_nopad
         assign rd_addr = {seg_q, off_q[VEC_W-1:1], state_q == S_RD1};
      end
      if (HI_FIRST) begin : g_hi_even
         assign routine = {first_q, rd_data};
      end else begin : g_lo_even
         assign routine = {rd_data, first_q};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= S_IDLE;
         kind_q       <= K_RESET;
         seg_q        <= '0;
         off_q        <= '0;
         first_q      <= '0;
         done         <= 1'b0;
         target       <= '0;
         no_flag_save <= 1'b0;
      end else begin
         done         <= 1'b0;
         no_flag_save <= 1'b0;
         unique case (state_q)
            S_IDLE: if (accept) begin
               kind_q  <= kind;
               seg_q   <= seg_in;
               off_q   <= off_in;
               state_q <= S_RD0;
            end
            S_RD0: state_q <= S_RD1;
            S_RD1: begin
               first_q <= rd_data;
               state_q <= S_CAP;
            end
            default: begin
               target       <= {seg_q, routine};
               done         <= 1'b1;
               no_flag_save <= (kind_q == K_DIVZ);
               state_q      <= S_IDLE;
            end
         endcase
      end
   end

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_even_first: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RD0) |-> (rd_en && !rd_addr[0]));
   a_r7_odd_next: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RD0) |=> (rd_en && rd_addr[0] && rd_addr[ADDR_W-1:1] == $past(rd_addr[ADDR_W-1:1])));
   a_r9_nfs_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      no_flag_save |-> done);
   a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> ($stable(seg_q) && $stable(off_q)));
   a_r8_done_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_CAP) |=> (done && !busy));
endmodule

// File: rtl/ivec_fetch.sv
module ivec_fetch
   import ivf_pkg::*;
#(
   parameter int SEG_W    = 8,
   parameter int VEC_W    = 8,
   parameter int CHAN_W   = 2,
   parameter int DATA_W   = 8,
   parameter bit HI_FIRST = 1'b1,
   localparam int ADDR_W  = SEG_W + 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [CHAN_W-1:0] req_chan,
   input  logic              vreg_wr,
   input  logic [VEC_W-1:0]  vreg_wdata,
   input  logic [SEG_W-1:0]  int_seg,
   input  logic [SEG_W-1:0]  code_seg,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              busy,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              done,
   output logic [ADDR_W-1:0] target,
   output logic              no_flag_save
);
   generate
      if (VEC_W > 2 * DATA_W) begin : g_bad_vec
         $error("vector offset wider than routine address");
      end
      if (CHAN_W + 1 >= VEC_W) begin : g_bad_chan
         $error("channel field leaves no base bits");
      end
      if (VEC_W < 3) begin : g_bad_fixed
         $error("offset too narrow for fixed trap slots");
      end
   endgenerate

   req_kind_t          kind;
   logic [VEC_W-1:0]   periph_off;
   logic [SEG_W-1:0]   sel_seg;
   logic [VEC_W-1:0]   sel_off;

   assign kind = req_kind_t'(req_kind);

   ivf_vecreg #(.VEC_W(VEC_W), .CHAN_W(CHAN_W)) u_vecreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (vreg_wr),
      .wr_data    (vreg_wdata),
      .chan       (req_chan),
      .periph_off (periph_off)
   );

   ivf_slot_sel #(.SEG_W(SEG_W), .VEC_W(VEC_W)) u_sel (
      .kind       (kind),
      .int_seg    (int_seg),
      .code_seg   (code_seg),
      .periph_off (periph_off),
      .seg        (sel_seg),
      .off        (sel_off)
   );

   ivf_seq #(.SEG_W(SEG_W), .VEC_W(VEC_W), .DATA_W(DATA_W), .HI_FIRST(HI_FIRST)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .kind         (kind),
      .seg_in       (sel_seg),
      .off_in       (sel_off),
      .rd_data      (mem_rd_data),
      .busy         (busy),
      .rd_en        (mem_rd_en),
      .rd_addr      (mem_addr),
      .done         (done),
      .target       (target),
      .no_flag_save (no_flag_save)
   );

   a_r2_reset_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && kind == K_RESET) |=> (mem_rd_en && mem_addr == '0));
   a_r3_divz_seg: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && kind == K_DIVZ) |=> (mem_addr[ADDR_W-1:ADDR_W-SEG_W] == $past(code_seg)));
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_rd_en);
endmodule

// File: tb/tb_ivec_fetch.sv
module tb_ivec_fetch;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [1:0]  req_chan = 2'd0;
   logic        vreg_wr = 1'b0;
   logic [7:0]  vreg_wdata = 8'h00;
   logic [7:0]  int_seg = 8'h00;
   logic [7:0]  code_seg = 8'h00;
   logic [7:0]  mem_rd_data = 8'h00;
   logic        busy, mem_rd_en, done, no_flag_save;
   logic [23:0] mem_addr, target;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ivec_fetch dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_chan(req_chan), .vreg_wr(vreg_wr), .vreg_wdata(vreg_wdata),
      .int_seg(int_seg), .code_seg(code_seg), .mem_rd_data(mem_rd_data),
      .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .done(done),
      .target(target), .no_flag_save(no_flag_save)
   );

   function automatic logic [7:0] fbyte(input logic [23:0] a);
      return (a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
   endfunction

   always @(posedge clk) mem_rd_data <= mem_rd_en ? fbyte(mem_addr) : 8'h00;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_base(input logic [7:0] v);
      @(negedge clk);
      vreg_wr = 1'b1; vreg_wdata = v;
      @(negedge clk);
      vreg_wr = 1'b0;
   endtask

   // mode 0 plain, 1 competing request mid-fetch, 2 segment change after accept
   task automatic run_req(input logic [1:0] kind, input logic [1:0] chan,
                          input logic [7:0] iseg, input logic [7:0] cseg,
                          input logic [7:0] eseg, input logic [7:0] eoff,
                          input string tag, input int mode);
      logic [23:0] ra0, ra1, tgt, ea;
      int nrd, ndone, got;
      logic nfs;
      ra0 = '0; ra1 = '0; tgt = '0; nfs = 1'b0; nrd = 0; ndone = 0; got = -1;
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_chan = chan; int_seg = iseg; code_seg = cseg;
      @(negedge clk);
      req_valid = 1'b0;
      if (mode == 2) begin int_seg = ~iseg; code_seg = ~cseg; end
      for (int n = 0; n < 8; n++) begin
         if (n > 0) @(negedge clk);
         if (mode == 1 && n == 1) begin req_valid = 1'b1; req_kind = 2'd2; req_chan = ~chan; end
         if (mode == 1 && n == 2) req_valid = 1'b0;
         if (mem_rd_en) begin
            if (nrd == 0) ra0 = mem_addr;
            if (nrd == 1) ra1 = mem_addr;
            nrd++;
         end
         if (done) begin
            if (got < 0) begin got = n; tgt = target; nfs = no_flag_save; end
            ndone++;
         end
      end
      ea = {eseg, 8'h00, eoff};
      chk(nrd == 2, mode == 1 ? "R10 read count" : "R7 read count", nrd, 2);
      chk(ra0 == ea, mode == 2 ? "R11 even address" : {tag, " even address"}, ra0, ea);
      chk(ra1 == (ea | 24'h1), "R7 odd address", ra1, ea | 24'h1);
      chk(got == 3, "R8 done latency", got, 3);
      chk(ndone == 1, "R8 single pulse", ndone, 1);
      chk(tgt == {eseg, fbyte(ea), fbyte(ea | 24'h1)}, mode == 0 ? {tag, " target"} : "R10/R11 target",
          tgt, {eseg, fbyte(ea), fbyte(ea | 24'h1)});
      chk(nfs == (kind == 2'd1), "R9 no_flag_save", nfs, kind == 2'd1);
   endtask

   // {kind, chan, vbase, iseg, cseg, eseg, eoff, r6}
   localparam logic [44:0] TBL [8] = '{
      {2'd0, 2'd0, 8'h00, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0},
      {2'd1, 2'd3, 8'h00, 8'h12, 8'h34, 8'h34, 8'h02, 1'b0},
      {2'd2, 2'd1, 8'h00, 8'h56, 8'h78, 8'h56, 8'h04, 1'b0},
      {2'd3, 2'd0, 8'hA8, 8'h9A, 8'hBC, 8'h9A, 8'hA8, 1'b0},
      {2'd3, 2'd3, 8'hA8, 8'h9A, 8'hBC, 8'h9A, 8'hAE, 1'b0},
      {2'd3, 2'd2, 8'h57, 8'h01, 8'h02, 8'h01, 8'h54, 1'b1},
      {2'd3, 2'd1, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFA, 1'b1},
      {2'd1, 2'd0, 8'hFF, 8'h11, 8'hEE, 8'hEE, 8'h02, 1'b0}
   };

   initial begin
      #(CLK_PERIOD * 100000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: idle state straight after reset
      chk(!busy && !done && !mem_rd_en && !no_flag_save, "R1 reset outputs",
          {busy, done, mem_rd_en, no_flag_save}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_rd_en, "R1 idle after release", {busy, done, mem_rd_en}, 0);
      // R1: base is zero, channel 2 -> offset 04h
      run_req(2'd3, 2'd2, 8'h40, 8'h41, 8'h40, 8'h04, "R1", 0);

      for (int i = 0; i < 8; i++) begin
         string tag;
         tag = TBL[i][0] ? "R6" :
               (TBL[i][44:43] == 2'd0) ? "R2" :
               (TBL[i][44:43] == 2'd1) ? "R3" :
               (TBL[i][44:43] == 2'd2) ? "R4" : "R5";
         write_base(TBL[i][40:33]);
         run_req(TBL[i][44:43], TBL[i][42:41], TBL[i][32:25], TBL[i][24:17],
                 TBL[i][16:9], TBL[i][8:1], tag, 0);
      end

      // R10: second request during the odd-byte read is ignored
      write_base(8'h20);
      run_req(2'd3, 2'd1, 8'h33, 8'h44, 8'h33, 8'h22, "R10", 1);
      repeat (3) @(negedge clk);
      chk(!busy && !mem_rd_en, "R10 stays idle", {busy, mem_rd_en}, 0);

      // R11: segment inputs changed after acceptance
      run_req(2'd1, 2'd0, 8'h5C, 8'h6D, 8'h6D, 8'h02, "R11", 2);
      run_req(2'd2, 2'd0, 8'h7E, 8'h01, 8'h7E, 8'h04, "R11", 2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule